// File: doc/BRIEF.md
# Dual-Row DDR Shift Serializer

The block turns a 10-bit code word into a serial stream that carries two bits per bit-clock period. The word is split between two 5-bit shift rows. Row one holds the odd-position bits and is clocked on the rising edge of the bit clock. Row two holds the even-position bits and is clocked on the falling edge. A 2:1 multiplexer steered by the clock level interleaves the two row heads onto one output, so the full word leaves in five bit-clock periods, most significant bit first.

A word is presented together with a one-cycle load strobe, which is sampled on a rising edge. Row two's half of the word is captured on that same rising edge and written into row two on the falling edge that follows, so the input word only has to be valid at the rising edge. To send words back to back, the strobe is raised on every fifth bit clock. When no strobe arrives, the rows shift in zeros and the output settles at 0.

Top module: `ddr_row_serializer`

## Requirements
- R1: While rst_ni is low, and after it is released with no load applied, ser_o is 0.
- R2: A rising edge of clk_i with load_i=1 takes word_i, and ser_o shows word_i[9] for the whole high phase that follows that edge.
- R3: For k = 0..4 after a load edge, the high phase of cycle k shows word[9-2k] and the low phase shows word[8-2k], so bit 9 leaves first and bit 0 leaves last.
- R4: Row two takes its half (bits 8, 6, 4, 2, 0) at the load edge and applies it on the next falling edge, so word_i may change after the rising edge without effect.
- R5: When clk_i is high, ser_o is driven by the head of the rising-edge row. When clk_i is low, it is driven by the head of the falling-edge row.
- R6: Without a load, each row shifts in 0. Once the ten bits of a word have left, ser_o stays 0 until the next load.
- R7: With load_i raised on every fifth cycle, consecutive words leave with no gap or repeated bit.
- R8: A load that arrives while a word is still shifting wins over the shift. The new word starts at that edge and the remaining bits of the old word are dropped.
- R9: Loading 1011001100 produces exactly the sequence 1,0,1,1,0,0,1,1,0,0 on ser_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; both edges are used |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | 10 | Parallel code word, bit 9 sent first |
| load_i | input | 1 | Load strobe, sampled on the rising edge |
| ser_o | output | 1 | Serial output, two bits per clock period |

## Verification
Load and shift can fall in the same cycle: a strobe that lands while a word is still draining asks both rows to shift and to load at once. The bench provokes this by raising load_i two cycles into a word. It also checks the normal case where the strobe meets the row heads exactly at the last bit, in the back-to-back stream. In both cases each high and low phase is compared with a bench model in which the load resets the bit index, so a dropped, repeated or stale bit shows up in the phase where it appears.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  localparam int unsigned ROW_W  = 5;
  localparam int unsigned WORD_W = 2 * ROW_W;
endpackage

// File: rtl/ser_shift_row.sv
module ser_shift_row #(
  parameter int unsigned ROW_W     = ddr_ser_pkg::ROW_W,
  parameter bit          FALL_EDGE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] data_i,
  output logic             head_o
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_d;

  // load wins over shift; zeros fill from the tail
  always_comb row_d = load_i ? data_i : {row_q[ROW_W-2:0], 1'b0};

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) row_q <= '0;
        else         row_q <= row_d;
      end

      AST_FALL_LOAD_HEAD: assert property (@(negedge clk_i) disable iff (!rst_ni)
        load_i |=> head_o == $past(data_i[ROW_W-1])); // R4
      AST_FALL_DRAIN: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !load_i |=> $countones(row_q) <= $past($countones(row_q))); // R6
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) row_q <= '0;
        else         row_q <= row_d;
      end

      AST_RISE_LOAD_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> head_o == $past(data_i[ROW_W-1])); // R2
      AST_RISE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $countones(row_q) <= $past($countones(row_q))); // R6
    end
  endgenerate

  assign head_o = row_q[ROW_W-1];
endmodule

// File: rtl/ser_fall_stage.sv
module ser_fall_stage #(
  parameter int unsigned ROW_W = ddr_ser_pkg::ROW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] data_i,
  output logic             load_o,
  output logic [ROW_W-1:0] data_o
);
  logic [ROW_W-1:0] stage_q;
  logic             load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= load_i;
      if (load_i) stage_q <= data_i;
    end
  end

  assign load_o = load_q;
  assign data_o = stage_q;

  AST_STAGE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> load_o && data_o == $past(data_i)); // R4
endmodule

// File: rtl/ser_out_mux.sv
module ser_out_mux (
  input  logic sel_i,
  input  logic row_one_i,
  input  logic row_two_i,
  output logic ser_o
);
  assign ser_o = sel_i ? row_two_i : row_one_i;
endmodule

// File: rtl/ddr_row_serializer.sv
module ddr_row_serializer #(
  parameter int unsigned ROW_W  = ddr_ser_pkg::ROW_W,
  localparam int unsigned WORD_W = 2 * ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  output logic              ser_o
);
  logic [ROW_W-1:0] odd_half;
  logic [ROW_W-1:0] even_half;
  logic [ROW_W-1:0] even_staged;
  logic             even_load;
  logic             head_one;
  logic             head_two;

  for (genvar k = 0; k < ROW_W; k++) begin : g_split
    assign odd_half[k]  = word_i[2*k+1];
    assign even_half[k] = word_i[2*k];
  end

  ser_shift_row #(.ROW_W(ROW_W), .FALL_EDGE(1'b0)) u_row_one (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .data_i(odd_half), .head_o(head_one)
  );

  ser_fall_stage #(.ROW_W(ROW_W)) u_stage (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load_i), .data_i(even_half),
    .load_o(even_load), .data_o(even_staged)
  );

  ser_shift_row #(.ROW_W(ROW_W), .FALL_EDGE(1'b1)) u_row_two (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(even_load),
    .data_i(even_staged), .head_o(head_two)
  );

  // high phase -> select 0 -> row one
  ser_out_mux u_mux (
    .sel_i(~clk_i), .row_one_i(head_one), .row_two_i(head_two), .ser_o(ser_o)
  );

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (ser_o == 1'b0); // R1
  end
endmodule

// File: tb/ddr_row_serializer_bench.sv
module ddr_row_serializer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] word_i = '0;
  logic       load_i = 1'b0;
  logic       ser_o;

  int checks = 0;
  int fails  = 0;

  logic [9:0] m_word = '0;
  int         m_idx  = 5;

  localparam int NV = 6;
  localparam logic [9:0] VEC [NV] = '{10'b1011001100, 10'h3FF, 10'h000,
                                      10'h2AA, 10'h155, 10'h0F3};

  always #5 clk_i = ~clk_i;

  ddr_row_serializer u_ddr_row_serializer (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i), .load_i(load_i), .ser_o(ser_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t ser_o=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic logic m_hi();
    return (m_idx < 5) ? m_word[9-2*m_idx] : 1'b0;
  endfunction
  function automatic logic m_lo();
    return (m_idx < 5) ? m_word[8-2*m_idx] : 1'b0;
  endfunction

  // one bit clock: drive, capture edge, check high phase then low phase
  task automatic step(input logic ld, input logic [9:0] w, input string tag);
    load_i = ld;
    word_i = w;
    @(posedge clk_i);
    if (ld) begin m_word = w; m_idx = 0; end
    else if (m_idx < 5) m_idx++;
    #3;
    load_i = 1'b0;
    word_i = ~w; // R4: word may change after the edge
    check(tag, ser_o, m_hi());
    @(negedge clk_i);
    #3;
    check(tag, ser_o, m_lo());
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    // R1: during reset
    repeat (2) begin
      @(posedge clk_i); #3 check("R1 reset high", ser_o, 1'b0);
      @(negedge clk_i); #3 check("R1 reset low", ser_o, 1'b0);
    end
    rst_ni = 1'b1;
    repeat (2) step(1'b0, 10'h3FF, "R1 idle after reset");

    // R9 / R3 / R5: single pattern, drained to zero (R6)
    for (int c = 0; c < 5; c++)
      step(c == 0, (c == 0) ? 10'b1011001100 : 10'h000, "R9 pattern");
    for (int c = 0; c < 4; c++) step(1'b0, 10'h3FF, "R6 drain zero");

    // R7: vector table back to back, load every fifth cycle
    for (int v = 0; v < NV; v++)
      for (int c = 0; c < 5; c++)
        step(c == 0, (c == 0) ? VEC[v] : 10'h2AA, "R7 R3 stream");
    for (int c = 0; c < 6; c++) step(1'b0, 10'h155, "R6 drain after stream");

    // R8: reload while a word is shifting
    step(1'b1, 10'h3FF, "R8 first word");
    step(1'b0, 10'h000, "R8 first word");
    step(1'b1, 10'h0A5, "R8 reload");
    for (int c = 0; c < 6; c++) step(1'b0, 10'h3FF, "R8 after reload");

    // R2 / R5: single-bit words isolate each position
    for (int b = 0; b < 10; b++)
      for (int c = 0; c < 5; c++)
        step(c == 0, (c == 0) ? (10'd1 << b) : 10'h000, "R2 R5 walking one");
    step(1'b0, 10'h000, "R6 final idle");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule